// File: doc/BRIEF.md
# 4:2:2 YCbCr Input Formatter and Chroma Upsampler

This block takes component video arriving as 4:2:2 YCbCr and turns it into one full 4:4:4 pixel per output strobe. The source can use either of two bus modes. In narrow mode a single byte bus carries the components one after another. In wide mode a luma bus carries one Y per cycle and a second bus carries the two chroma components in turn. While the active-video qualifier is high, the block sorts the incoming bytes into their components. It raises any luma value below black to the black level. It builds the chroma for each odd pixel as the rounded mean of the two co-sited chroma samples on either side of it.

Each line is handled as a run of chroma pairs. A pair is two pixels that share one Cb and one Cr. A pair can only be emitted once the next pair's chroma has arrived. When the qualifier falls, the last pair is flushed out. Its odd pixel reuses the pair's own chroma, because no right-hand neighbour exists. The control is a five-state machine:

- `S_IDLE` waits for the qualifier. When the qualifier goes high it takes the first Cb and moves to `S_FIRST`.
- `S_FIRST` collects the first pair of a line. It moves to `S_STREAM` when the pair is complete. It returns to `S_IDLE` if the qualifier drops first, and the partial pair is dropped.
- `S_STREAM` collects each later pair and emits the pending pair while doing so. It moves to `S_FLUSH_EVEN` when the qualifier drops.
- `S_FLUSH_EVEN` emits the even pixel of the last pair and moves to `S_FLUSH_ODD`.
- `S_FLUSH_ODD` emits the odd pixel of the last pair and returns to `S_IDLE`.

Top module: `ycc422_upsampler`

## Requirements
- R1: In narrow mode (`wide_mode`=0) the bytes on `mux_in` are taken in the repeating order Cb, Y(even pixel), Cr, Y(odd pixel). The first active byte of each line is Cb.
- R2: In wide mode (`wide_mode`=1), `luma_in` carries Y on every active cycle. `mux_in` carries Cb on the first cycle of each pair and Cr on the second.
- R3: An output luma below 16 is replaced by 16.
- R4: Luma above 235 is passed unchanged. Cb and Cr are never clamped at any value from 0 to 255.
- R5: The even pixel of a pair carries that pair's own Cb and Cr.
- R6: The odd pixel of a pair that is not the last in its line carries (this + next + 1) >> 1 for each chroma component, where "next" is the following pair's sample.
- R7: The odd pixel of the last pair in a line repeats that pair's Cb and Cr. It follows the even pixel on the next cycle, when the qualifier has been low for at least three cycles.
- R8: The component order restarts at every rising edge of `act_in`. A pair left incomplete when `act_in` falls during the first pair of a line produces no output.
- R9: Timing, counting clock edges from the edge that samples a pair's first input:
  - Wide mode, not the last pair: the even pixel is valid 2 edges later and the odd pixel 3 edges later.
  - Narrow mode, not the last pair: the even pixel is valid 5 edges later and the odd pixel 7 edges later.
  - Last pair of a line: the two pixels appear 1 and 2 edges after the edge that samples `act_in` low.
- R10: `pix_sol` is high together with `pix_valid` on the first output pixel of each line, and at no other time.
- R11: While streaming in narrow mode, one pixel is produced for every two input bytes. `pix_valid` is never high on two adjacent cycles, except during the end-of-line flush.
- R12: After reset, and on every cycle following one spent in `S_IDLE`, `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = separate luma and chroma buses, 0 = single multiplexed byte bus; held constant within a line |
| act_in | input | 1 | Active-video qualifier; a line spans whole pairs |
| luma_in | input | DW (8) | Luma bus in wide mode; unused in narrow mode |
| mux_in | input | DW (8) | Multiplexed byte bus (narrow) or chroma bus (wide) |
| pix_valid | output | 1 | Output pixel strobe |
| pix_sol | output | 1 | First output pixel of a line |
| pix_y | output | DW (8) | Output luma |
| pix_cb | output | DW (8) | Output Cb |
| pix_cr | output | DW (8) | Output Cr |

## Verification
The assertions check the following on every cycle:
- no luma below the floor ever leaves the block;
- the line-start flag only appears with a valid pixel;
- the state machine stays quiet while idle;
- the two flush states each yield a pixel, and the final one repeats the previous chroma;
- narrow-mode streaming never produces back-to-back pixels.

Other behaviours can only be shown by the bench's scenarios against its reference model:
- the byte ordering in each bus mode;
- the rounding of interpolated chroma;
- the exact output latency;
- that a truncated first pair is dropped and the component order realigns on the following line.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_FIRST      = 3'd1,
        S_STREAM     = 3'd2,
        S_FLUSH_EVEN = 3'd3,
        S_FLUSH_ODD  = 3'd4
    } fmt_state_e;

    localparam int PHASE_W = 2;

endpackage

// File: rtl/ycc_luma_floor.sv
module ycc_luma_floor #(
    parameter int DW    = 8,
    parameter int FLOOR = 16
) (
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] floored
);
    localparam logic [DW-1:0] FLOOR_V = DW'(FLOOR);

    always_comb begin
        floored = (raw < FLOOR_V) ? FLOOR_V : raw;
    end
endmodule

// File: rtl/ycc_chroma_mean.sv
module ycc_chroma_mean #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] left,
    input  logic [DW-1:0] right,
    output logic [DW-1:0] mean
);
    localparam int SW = DW + 1;
    logic [SW-1:0] sum;

    always_comb begin
        sum  = {1'b0, left} + {1'b0, right} + SW'(1);
        mean = sum[SW-1:1];
    end
endmodule

// File: rtl/ycc422_upsampler.sv
module ycc422_upsampler
    import ycc_fmt_pkg::*;
#(
    parameter int DW      = 8,
    parameter int Y_FLOOR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          act_in,
    input  logic [DW-1:0] luma_in,
    input  logic [DW-1:0] mux_in,
    output logic          pix_valid,
    output logic          pix_sol,
    output logic [DW-1:0] pix_y,
    output logic [DW-1:0] pix_cb,
    output logic [DW-1:0] pix_cr
);
    localparam int NCH = 2;
    localparam logic [PHASE_W-1:0] LAST_NARROW = PHASE_W'(3);
    localparam logic [PHASE_W-1:0] LAST_WIDE   = PHASE_W'(1);

    fmt_state_e state_q, state_d;
    logic [PHASE_W-1:0] phase_q, ph, last_ph;
    logic sol_pend_q;

    // pair being collected
    logic [DW-1:0] c_cb, c_cr, c_y0;
    // pending pair awaiting emission
    logic [DW-1:0] h_y0, h_y1;
    logic [DW-1:0] h_c  [NCH];
    logic [DW-1:0] nx_c [NCH];
    logic [DW-1:0] av_c [NCH];

    logic cap, pair_done, emit_even, emit_odd;
    logic [DW-1:0] new_cr, new_y1, y_sel, y_cl;

    // ---------------- control decode ----------------
    always_comb begin
        last_ph   = wide_mode ? LAST_WIDE : LAST_NARROW;
        cap       = act_in && (state_q == S_IDLE || state_q == S_FIRST || state_q == S_STREAM);
        ph        = (state_q == S_IDLE) ? '0 : phase_q;
        pair_done = cap && (ph == last_ph);
        new_cr    = wide_mode ? mux_in : c_cr;
        new_y1    = wide_mode ? luma_in : mux_in;
        emit_even = (state_q == S_FLUSH_EVEN) ||
                    ((state_q == S_STREAM) && cap &&
                     (ph == (wide_mode ? PHASE_W'(0) : PHASE_W'(1))));
        emit_odd  = (state_q == S_FLUSH_ODD) || ((state_q == S_STREAM) && pair_done);
        nx_c[0]   = (state_q == S_FLUSH_ODD) ? h_c[0] : c_cb;
        nx_c[1]   = (state_q == S_FLUSH_ODD) ? h_c[1] : new_cr;
        y_sel     = emit_even ? h_y0 : h_y1;
    end

    ycc_luma_floor #(.DW(DW), .FLOOR(Y_FLOOR)) u_floor (
        .raw     (y_sel),
        .floored (y_cl)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_mean
        ycc_chroma_mean #(.DW(DW)) u_mean (
            .left  (h_c[gi]),
            .right (nx_c[gi]),
            .mean  (av_c[gi])
        );
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (act_in) state_d = S_FIRST;
            S_FIRST:      if (!act_in) state_d = S_IDLE;
                          else if (pair_done) state_d = S_STREAM;
            S_STREAM:     if (!act_in) state_d = S_FLUSH_EVEN;
            S_FLUSH_EVEN: state_d = S_FLUSH_ODD;
            S_FLUSH_ODD:  state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= (cap && !pair_done) ? ph + PHASE_W'(1) : '0;
        end
    end

    // ---------------- capture and outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_cb <= '0; c_cr <= '0; c_y0 <= '0;
            h_y0 <= '0; h_y1 <= '0;
            h_c[0] <= '0; h_c[1] <= '0;
            sol_pend_q <= 1'b0;
            pix_valid <= 1'b0; pix_sol <= 1'b0;
            pix_y <= '0; pix_cb <= '0; pix_cr <= '0;
        end else begin
            if (cap) begin
                if (wide_mode) begin
                    if (ph == PHASE_W'(0)) begin
                        c_cb <= mux_in;
                        c_y0 <= luma_in;
                    end
                end else begin
                    unique case (ph)
                        PHASE_W'(0): c_cb <= mux_in;
                        PHASE_W'(1): c_y0 <= mux_in;
                        PHASE_W'(2): c_cr <= mux_in;
                        default: ;
                    endcase
                end
            end
            if (pair_done) begin
                h_c[0] <= c_cb;
                h_c[1] <= new_cr;
                h_y0   <= c_y0;
                h_y1   <= new_y1;
            end
            if (state_q == S_IDLE && act_in)
                sol_pend_q <= 1'b1;
            else if (emit_even || emit_odd)
                sol_pend_q <= 1'b0;

            pix_valid <= emit_even || emit_odd;
            pix_sol   <= (emit_even || emit_odd) && sol_pend_q;
            if (emit_even || emit_odd) begin
                pix_y  <= y_cl;
                pix_cb <= emit_even ? h_c[0] : av_c[0];
                pix_cr <= emit_even ? h_c[1] : av_c[1];
            end
        end
    end

    // ---------------- assertions ----------------
    assert_luma_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_y >= DW'(Y_FLOOR)));

    assert_sol_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sol |-> pix_valid);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !pix_valid);

    assert_flush_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH_EVEN) |=> pix_valid);

    assert_flush_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH_ODD) |=> (pix_valid && $stable(pix_cb) && $stable(pix_cr)));

    assert_narrow_rate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STREAM && !wide_mode && pix_valid) |=> !pix_valid);

endmodule

// File: tb/sim_ycc422_upsampler.sv
module sim_ycc422_upsampler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wide_mode = 1'b0;
    logic act_in = 1'b0;
    logic [7:0] luma_in = '0;
    logic [7:0] mux_in = '0;
    logic pix_valid, pix_sol;
    logic [7:0] pix_y, pix_cb, pix_cr;

    always #5 clk = ~clk;

    ycc422_upsampler u0 (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .act_in(act_in),
        .luma_in(luma_in), .mux_in(mux_in),
        .pix_valid(pix_valid), .pix_sol(pix_sol),
        .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr)
    );

    typedef struct {
        int    e;
        int    y;
        int    cb;
        int    cr;
        bit    sol;
        string tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_on = 0;
    int gy[64];
    int gcb[32];
    int gcr[32];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int floor_y(input int v);
        return (v < 16) ? 16 : v;
    endfunction

    // reference model comparison on every clock (R9 timing, fields per tag)
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            checks++;
            if (q.size() > 0 && q[0].e == cyc) begin
                exp_t x;
                x = q.pop_front();
                if (!pix_valid || pix_y != 8'(x.y) || pix_cb != 8'(x.cb) ||
                    pix_cr != 8'(x.cr) || pix_sol != x.sol) begin
                    fails++;
                    $display("FAIL %s/R9 cyc=%0d got v=%0b y=%0d cb=%0d cr=%0d sol=%0b exp v=1 y=%0d cb=%0d cr=%0d sol=%0b",
                             x.tag, cyc, pix_valid, pix_y, pix_cb, pix_cr, pix_sol,
                             x.y, x.cb, x.cr, x.sol);
                end
            end else if (pix_valid) begin
                fails++;
                $display("FAIL R9/R11 cyc=%0d got unexpected pixel v=1 y=%0d exp v=0", cyc, pix_y);
            end
        end
    end

    task automatic fill(input int base);
        for (int i = 0; i < 64; i++) gy[i] = (base + i * 29) & 255;
        for (int k = 0; k < 32; k++) begin
            gcb[k] = (base + k * 71) & 255;
            gcr[k] = (base * 3 + k * 113 + 5) & 255;
        end
    endtask

    task automatic push_pair(input int k, input int np, input int c0, input bit w);
        exp_t ev, od;
        ev.y = floor_y(gy[2*k]); ev.cb = gcb[k]; ev.cr = gcr[k];
        ev.sol = (k == 0); ev.tag = (k == 0) ? "R10/R5" : "R5";
        od.y = floor_y(gy[2*k+1]); od.sol = 0;
        if (k < np - 1) begin
            ev.e = c0 + (w ? 2 : 5);
            od.e = c0 + (w ? 3 : 7);
            od.cb = (gcb[k] + gcb[k+1] + 1) >> 1;
            od.cr = (gcr[k] + gcr[k+1] + 1) >> 1;
            od.tag = "R6";
        end else begin
            ev.e = c0 + (w ? 2 : 4) + 1;
            od.e = ev.e + 1;
            od.cb = gcb[k]; od.cr = gcr[k];
            od.tag = "R7";
        end
        q.push_back(ev);
        q.push_back(od);
    endtask

    // drives one line of np pairs, then a blanking gap
    task automatic run_line(input bit w, input int np, input int gap);
        wide_mode = w;
        for (int k = 0; k < np; k++) begin
            int c0;
            c0 = cyc + 1;
            push_pair(k, np, c0, w);
            act_in = 1'b1;
            if (w) begin
                mux_in = 8'(gcb[k]); luma_in = 8'(gy[2*k]);
                @(posedge clk); #1;
                mux_in = 8'(gcr[k]); luma_in = 8'(gy[2*k+1]);
                @(posedge clk); #1;
            end else begin
                luma_in = 8'hA5;
                mux_in = 8'(gcb[k]);    @(posedge clk); #1;
                mux_in = 8'(gy[2*k]);   @(posedge clk); #1;
                mux_in = 8'(gcr[k]);    @(posedge clk); #1;
                mux_in = 8'(gy[2*k+1]); @(posedge clk); #1;
            end
        end
        act_in = 1'b0;
        mux_in = 8'h5A;
        repeat (gap) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            if (q.size() != 0) begin
                checks++; fails++;
                $display("FAIL R9 %0d expected pixels never appeared (got 0 exp %0d)", q.size(), q.size());
            end
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired got running exp finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;  // R12: reset state
        if (pix_valid !== 1'b0 || pix_sol !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset got v=%0b sol=%0b exp 0 0", pix_valid, pix_sol);
        end
        @(posedge clk); #1;
        cmp_on = 1;

        // R2 wide bus, R3 low luma floor, R4 high luma and chroma extremes
        for (int i = 0; i < 64; i++) gy[i] = (i * 53 + 7) & 255;
        gy[0] = 0; gy[1] = 15; gy[2] = 16; gy[3] = 17; gy[4] = 235; gy[5] = 236; gy[6] = 255; gy[7] = 1;
        for (int k = 0; k < 32; k++) begin gcb[k] = (k * 97) & 255; gcr[k] = (255 - k * 31) & 255; end
        gcb[0] = 0; gcb[1] = 255; gcb[2] = 1; gcb[3] = 254;
        gcr[0] = 255; gcr[1] = 0; gcr[2] = 240; gcr[3] = 241;
        run_line(1'b1, 6, 5);

        // R1 narrow bus, R4, R11 rate with the same directed values
        run_line(1'b0, 6, 5);

        // R6 rounding and R7 repeat under several patterns in both modes
        fill(3);   run_line(1'b1, 10, 4);
        fill(200); run_line(1'b0, 9, 4);
        fill(77);  run_line(1'b1, 1, 4);   // single pair: R7, R10
        fill(140); run_line(1'b0, 1, 4);

        // R8: truncated first pair gives no output, then the order realigns
        wide_mode = 1'b0;
        act_in = 1'b1; mux_in = 8'h11; @(posedge clk); #1;
        mux_in = 8'h22; @(posedge clk); #1;
        mux_in = 8'h33; @(posedge clk); #1;
        act_in = 1'b0; repeat (4) begin @(posedge clk); #1; end
        fill(9); run_line(1'b0, 4, 4);
        wide_mode = 1'b1;
        act_in = 1'b1; mux_in = 8'h44; luma_in = 8'h02; @(posedge clk); #1;
        act_in = 1'b0; repeat (4) begin @(posedge clk); #1; end
        fill(250); run_line(1'b1, 5, 6);

        repeat (10) begin @(posedge clk); #1; end
        finish_run();
    end
endmodule